// File: doc/BRIEF.md
# Registered Two's-Complement Adder-Subtractor with Selectable Carry Chain

This block adds or subtracts two signed fixed-point operands and presents the result from a register. The operation is picked each cycle by a one-bit control input. A build-time polarity parameter sets what that control means. With `POLARITY` = 1, a high control adds and a low control subtracts. With `POLARITY` = 0 the two meanings swap. A second build-time parameter picks the carry structure. One choice is a plain ripple chain. The other splits the chain into fixed-width groups, and a group's incoming carry skips straight to its output whenever every bit in the group propagates.

The operands are sign-extended by one bit before they reach the chain, so the internal sum is always exact. Subtraction inverts the second operand and injects a carry-in of one. The exact sum is then rescaled by an arithmetic right shift of `OUT_SHIFT` places. The shifted value is fitted to `OUT_W` bits: upper bits are dropped when the output is narrower, and the sign is extended when it is wider. The rescaled value is loaded into the output register on a rising clock edge, but only while the enable input is high. The block is meant to settle within one sample period of the surrounding datapath.

Top module: `addsub_unit`

## Requirements
- R1: With `POLARITY` = 1, a high `add_ctl` gives `op_a + op_b` and a low `add_ctl` gives `op_a - op_b`.
- R2: With `POLARITY` = 0, a high `add_ctl` gives `op_a - op_b` and a low `add_ctl` gives `op_a + op_b`.
- R3: The internal sum is `IN_W`+1 bits wide, so every pair of operands gives the exact sum or difference. For example, -32768 - 32767 = -65535 with 16-bit inputs.
- R4: For either carry structure, the carry chain returns the exact sum of its two inputs and its carry-in, taken modulo 2^(`IN_W`+1).
- R5: The carry-bypass and ripple structures give bit-identical results for all inputs. In the bypass structure, each group's skipped carry equals the carry its internal ripple would have produced.
- R6: While `en` is low, `result` holds its value whatever the operands and the control do.
- R7: An active-low `rst_n` clears `result` to zero asynchronously, and it stays zero until the first enabled rising edge after release.
- R8: `result` is the exact sum arithmetically shifted right by `OUT_SHIFT` places (rounding toward minus infinity), then reduced to its low `OUT_W` bits. When `OUT_W` exceeds the shifted width, the value is sign-extended.
- R9: Operands sampled at a rising edge with `en` high appear on `result` right after that same edge (one register of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the output register |
| add_ctl | input | 1 | Runtime add/subtract select, meaning set by `POLARITY` |
| op_a | input | IN_W | First signed operand |
| op_b | input | IN_W | Second signed operand |
| result | output | OUT_W | Registered, rescaled signed result |

## Verification
Embedded assertions check four things on every cycle. The carry chain must agree with an exact sum of its inputs. In the bypass structure, every skipped group carry must equal that group's ripple carry. The output must hold while the enable is low. The output must read zero on the first edge after reset is released. Other behaviour appears only in the bench's scenarios, which run several instances built with different parameters on the same stimulus. These scenarios show whether the polarity parameter really inverts the control. They show whether the shift and truncation or sign extension land on the expected bits. They also confirm that the two carry structures agree on whole results for both directed corners and random operands.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic {
        CARRY_RIPPLE = 1'b0,
        CARRY_BYPASS = 1'b1
    } carry_arch_e;
endpackage

// File: rtl/addsub_carry_chain.sv
module addsub_carry_chain #(
    parameter int                      W       = 17,
    parameter int                      GROUP_W = 4,
    parameter addsub_pkg::carry_arch_e ARCH    = addsub_pkg::CARRY_BYPASS
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    localparam int NGRP = (W + GROUP_W - 1) / GROUP_W;
    localparam int WP   = NGRP * GROUP_W;

    logic [WP-1:0] a_pad, b_pad, prop, gen;
    logic [WP:0]   carry;
    logic          unused_hi;

    assign a_pad    = WP'(a);
    assign b_pad    = WP'(b);
    assign prop     = a_pad ^ b_pad;
    assign gen      = a_pad & b_pad;
    assign carry[0] = cin;

    generate
        if (ARCH == addsub_pkg::CARRY_RIPPLE) begin : g_ripple
            for (genvar i = 0; i < WP; i++) begin : g_bit
                assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
            end
        end else begin : g_bypass
            for (genvar j = 0; j < NGRP; j++) begin : g_grp
                logic [GROUP_W:0] rc;
                logic             all_prop;
                assign rc[0]    = carry[j*GROUP_W];
                assign all_prop = &prop[j*GROUP_W +: GROUP_W];
                for (genvar k = 0; k < GROUP_W; k++) begin : g_bit
                    assign rc[k+1] = gen[j*GROUP_W+k] | (prop[j*GROUP_W+k] & rc[k]);
                    if (k > 0) begin : g_int
                        assign carry[j*GROUP_W+k] = rc[k];
                    end
                end
                assign carry[(j+1)*GROUP_W] = all_prop ? carry[j*GROUP_W] : rc[GROUP_W];

                // R5: the skipped carry must agree with the group's own ripple
                always_comb begin
                    if (!$isunknown({all_prop, rc})) begin
                        a_r5_skip_equals_ripple: assert (carry[(j+1)*GROUP_W] == rc[GROUP_W])
                            else $error("group %0d skip carry differs from ripple", j);
                    end
                end
            end
        end
    endgenerate

    assign sum       = prop[W-1:0] ^ carry[W-1:0];
    assign unused_hi = ^{carry, prop};

    // R4: the gate-level chain must match an exact behavioural sum
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            a_r4_chain_exact: assert (sum == W'(a + b + W'(cin)))
                else $error("carry chain sum mismatch");
        end
    end
endmodule

// File: rtl/addsub_fit.sv
module addsub_fit #(
    parameter int IN_W  = 17,
    parameter int OUT_W = 18,
    parameter int SHIFT = 0
) (
    input  logic [IN_W-1:0]  d,
    output logic [OUT_W-1:0] q
);
    localparam int EXT_W = IN_W + OUT_W + SHIFT;

    logic signed [EXT_W-1:0] ext;

    assign ext = {{(EXT_W-IN_W){d[IN_W-1]}}, d};
    assign q   = OUT_W'(ext >>> SHIFT);
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
    parameter int                      IN_W      = 16,
    parameter int                      OUT_W     = 18,
    parameter int                      OUT_SHIFT = 0,
    parameter bit                      POLARITY  = 1'b1,
    parameter addsub_pkg::carry_arch_e ARCH      = addsub_pkg::CARRY_BYPASS,
    parameter int                      GROUP_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             add_ctl,
    input  logic [IN_W-1:0]  op_a,
    input  logic [IN_W-1:0]  op_b,
    output logic [OUT_W-1:0] result
);
    localparam int SUM_W = IN_W + 1;

    logic             do_sub;
    logic [SUM_W-1:0] a_ext, b_ext, b_in, sum_q;
    logic [OUT_W-1:0] fitted;

    assign do_sub = POLARITY ? ~add_ctl : add_ctl;
    assign a_ext  = {op_a[IN_W-1], op_a};
    assign b_ext  = {op_b[IN_W-1], op_b};
    assign b_in   = b_ext ^ {SUM_W{do_sub}};

    addsub_carry_chain #(
        .W       (SUM_W),
        .GROUP_W (GROUP_W),
        .ARCH    (ARCH)
    ) i_chain (
        .a   (a_ext),
        .b   (b_in),
        .cin (do_sub),
        .sum (sum_q)
    );

    addsub_fit #(
        .IN_W  (SUM_W),
        .OUT_W (OUT_W),
        .SHIFT (OUT_SHIFT)
    ) i_fit (
        .d (sum_q),
        .q (fitted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (en) begin
            result <= fitted;
        end
    end

    // R6: a disabled cycle leaves the output untouched
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result));

    // R7: output reads zero at the first edge after reset release
    a_r7_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result == '0));
endmodule

// File: tb/test_addsub_unit.sv
module test_addsub_unit;
    localparam int CLK_P = 10;
    localparam int IN_W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic            add_ctl = 1'b0;
    logic [IN_W-1:0] opa = '0;
    logic [IN_W-1:0] opb = '0;
    logic [17:0]     r0, r1, r2;
    logic [11:0]     r3;
    logic [23:0]     r4;
    int              n_chk = 0;
    int              n_err = 0;
    bit              done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    addsub_unit i_addsub_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .add_ctl(add_ctl),
        .op_a(opa), .op_b(opb), .result(r0));

    addsub_unit #(.ARCH(addsub_pkg::CARRY_RIPPLE)) i_addsub_unit_rip (
        .clk(clk), .rst_n(rst_n), .en(en), .add_ctl(add_ctl),
        .op_a(opa), .op_b(opb), .result(r1));

    addsub_unit #(.POLARITY(1'b0)) i_addsub_unit_pol0 (
        .clk(clk), .rst_n(rst_n), .en(en), .add_ctl(add_ctl),
        .op_a(opa), .op_b(opb), .result(r2));

    addsub_unit #(.OUT_W(12), .OUT_SHIFT(3)) i_addsub_unit_narrow (
        .clk(clk), .rst_n(rst_n), .en(en), .add_ctl(add_ctl),
        .op_a(opa), .op_b(opb), .result(r3));

    addsub_unit #(.OUT_W(24), .OUT_SHIFT(1), .POLARITY(1'b0),
                  .ARCH(addsub_pkg::CARRY_RIPPLE)) i_addsub_unit_wide (
        .clk(clk), .rst_n(rst_n), .en(en), .add_ctl(add_ctl),
        .op_a(opa), .op_b(opb), .result(r4));

    function automatic logic [31:0] model(int a, int b, bit ad, bit pol, int sh, int w);
        int s;
        if (pol) s = ad ? a + b : a - b;
        else     s = ad ? a - b : a + b;
        s = s >>> sh;
        return 32'(s) & ((32'd1 << w) - 32'd1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Drive at a falling edge, let one rising edge load, sample at the next falling edge.
    task automatic step(int a, int b, bit ad, string tag);
        opa = 16'(a); opb = 16'(b); add_ctl = ad; en = 1'b1;
        @(negedge clk);
        chk({tag, " R1 R3 R9 pol1 bypass"}, 32'(r0), model(a, b, ad, 1'b1, 0, 18));
        chk({tag, " R4 pol1 ripple"},       32'(r1), model(a, b, ad, 1'b1, 0, 18));
        chk({tag, " R5 bypass vs ripple"},  32'(r0), 32'(r1));
        chk({tag, " R2 pol0 bypass"},       32'(r2), model(a, b, ad, 1'b0, 0, 18));
        chk({tag, " R8 narrow shift3"},     32'(r3), model(a, b, ad, 1'b1, 3, 12));
        chk({tag, " R8 wide shift1 pol0"},  32'(r4), model(a, b, ad, 1'b0, 1, 24));
    endtask

    initial begin
        #(CLK_P * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R7: held in reset
        chk("R7 reset r0", 32'(r0), 32'd0);
        chk("R7 reset r3", 32'(r3), 32'd0);
        chk("R7 reset r4", 32'(r4), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 after release, en low", 32'(r0), 32'd0);

        // directed corners
        step( 32767,  32767, 1'b1, "max+max");
        step(-32768, -32768, 1'b1, "min+min");
        step(-32768,  32767, 1'b0, "min-max");
        step( 32767, -32768, 1'b0, "max-min");
        step(     0,      0, 1'b0, "zero-zero");
        step(    -1,      1, 1'b1, "full propagate");
        step(    -1,     -1, 1'b0, "self subtract");
        step(    -5,      2, 1'b1, "floor shift");
        step( 21845, -21846, 1'b1, "alternating");

        // R6: hold while disabled
        step(1234, -567, 1'b1, "pre-hold");
        begin
            logic [31:0] e0, e2;
            e0 = model(1234, -567, 1'b1, 1'b1, 0, 18);
            e2 = model(1234, -567, 1'b1, 1'b0, 0, 18);
            en = 1'b0; opa = 16'h7000; opb = 16'h8123; add_ctl = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk("R6 hold r0", 32'(r0), e0);
            chk("R6 hold r2", 32'(r2), e2);
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int a, b;
            a = int'($signed(16'($urandom)));
            b = int'($signed(16'($urandom)));
            step(a, b, 1'($urandom), "random");
        end

        // R7: asynchronous clear in mid-run
        rst_n = 1'b0;
        #1;
        chk("R7 async clear r0", 32'(r0), 32'd0);
        chk("R7 async clear r1", 32'(r1), 32'd0);
        chk("R7 async clear r4", 32'(r4), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(-100, 58, 1'b0, "post reset");

        finish_run();
    end
endmodule